// File: doc/BRIEF.md
# Polymorphic Netlist Fitness Evaluator

This block scores a small candidate netlist of dual-behaviour gates against two target truth tables, one for each operating mode. Each gate has two behaviours. Which one applies depends on a global mode bit, and every gate in the netlist follows the same mode bit. The netlist sits in a register array that is written through a load port. Each entry holds a gate kind and two source indices. A source is either a primary input or a gate with a lower number.

After a start request, the engine steps through every input combination. For each combination it evaluates the netlist one gate per clock with mode 1 behaviour, and then repeats the evaluation with mode 2 behaviour. After each pass it compares the selected outputs with the target for that mode. A combination scores a point only when both passes match. When the last combination is done, the engine pulses done and holds the count until the next start. An evolutionary search loop outside the block supplies the candidates and reads the score.

Top module: `poly_fitness_eval`

## Requirements
- R1: While reset is active and after it is released, fitness_o is 0 and done_o is 0.
- R2: An accepted start clears fitness_o to 0 in the cycle after the start is sampled.
- R3: Gate kind code 0 computes NAND in mode 1 and NOR in mode 2. Code 1 computes OR in mode 1 and XOR in mode 2. Code 2 computes XOR in mode 1 and (NOT a) AND b in mode 2, where a is the first source. Code 3 outputs 0 in both modes.
- R4: A source index below NUM_IN selects bit idx of the current combination number, with bit 0 as input 0. Index NUM_IN+k selects gate k. Any index that names the current gate or a later one reads as 0.
- R5: Output bit o is the result of gate NUM_GATES-NUM_OUT+o. For combination c, the expected bit o is at position c*NUM_OUT+o of tgt_m1_i in mode 1 and of tgt_m2_i in mode 2.
- R6: After a run, fitness_o equals the number of combinations for which both the mode 1 output vector and the mode 2 output vector match their targets. The value never exceeds 2^NUM_IN.
- R7: done_o is high for exactly one cycle. It rises 2^NUM_IN*2*(NUM_GATES+1) clock edges after the edge that accepted the start.
- R8: Once done_o has pulsed, fitness_o stays unchanged until the next accepted start.
- R9: A start request that arrives during a run is ignored. The run completes with the same timing and the same count.
- R10: When load_en_i is high at a clock edge, the netlist entry load_idx_i takes the given kind and source indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request an evaluation run |
| load_en_i | input | 1 | Write one netlist entry |
| load_idx_i | input | GIDX_W | Gate number to write |
| load_kind_i | input | 2 | Gate kind code |
| load_src_a_i | input | SRC_W | First source index |
| load_src_b_i | input | SRC_W | Second source index |
| tgt_m1_i | input | 2^NUM_IN*NUM_OUT | Mode 1 target truth table |
| tgt_m2_i | input | 2^NUM_IN*NUM_OUT | Mode 2 target truth table |
| fitness_o | output | NUM_IN+1 | Number of combinations where both modes match |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The case of interest is a new start request arriving in the same cycle as a step of a run that is already in progress, for example a gate evaluation or a comparison. To provoke it, start is pulsed partway through a run. The run passes if done still rises on the cycle predicted from the original start and the count matches a reference score computed in the bench from the netlist and the targets. The other runs sweep pseudo-random netlists, some with sources that illegally point forward, and targets that have sparse flips applied, so that full, partial and zero scores all occur.

// File: rtl/pnf_pkg.sv
package pnf_pkg;
  typedef enum logic [1:0] {
    GK_NAND_NOR = 2'd0,
    GK_OR_XOR   = 2'd1,
    GK_XOR_ANDN = 2'd2,
    GK_ZERO     = 2'd3
  } gate_kind_e;

  // R3: dual-behaviour gate, m2 selects the mode 2 behaviour
  function automatic logic gate_eval(gate_kind_e k, logic m2, logic a, logic b);
    logic r;
    unique case (k)
      GK_NAND_NOR: r = m2 ? ~(a | b) : ~(a & b);
      GK_OR_XOR:   r = m2 ? (a ^ b) : (a | b);
      GK_XOR_ANDN: r = m2 ? (~a & b) : (a ^ b);
      default:     r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pnf_sequencer.sv
module pnf_sequencer #(
  parameter int NUM_IN    = 3,
  parameter int NUM_GATES = 6,
  localparam int GCNT_W   = $clog2(NUM_GATES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic [NUM_IN-1:0] combo_o,
  output logic              mode2_o,
  output logic [GCNT_W-1:0] gate_o,
  output logic              gate_fire_o,
  output logic              cmp_fire_o,
  output logic              last_cmp_o,
  output logic              start_acc_o
);
  localparam logic [GCNT_W-1:0] CMP_SLOT = GCNT_W'(NUM_GATES);

  logic              busy_q, mode2_q;
  logic [NUM_IN-1:0] combo_q;
  logic [GCNT_W-1:0] gate_q;

  assign start_acc_o = start_i && !busy_q;          // R9
  assign gate_fire_o = busy_q && (gate_q != CMP_SLOT);
  assign cmp_fire_o  = busy_q && (gate_q == CMP_SLOT);
  assign last_cmp_o  = cmp_fire_o && mode2_q && (combo_q == '1);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      mode2_q <= 1'b0;
      combo_q <= '0;
      gate_q  <= '0;
    end else if (start_acc_o) begin
      busy_q  <= 1'b1;
      mode2_q <= 1'b0;
      combo_q <= '0;
      gate_q  <= '0;
    end else if (busy_q) begin
      if (cmp_fire_o) begin
        gate_q <= '0;
        if (mode2_q) begin
          mode2_q <= 1'b0;
          combo_q <= combo_q + 1'b1;
          if (last_cmp_o) busy_q <= 1'b0;
        end else begin
          mode2_q <= 1'b1;
        end
      end else begin
        gate_q <= gate_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign combo_o = combo_q;
  assign mode2_o = mode2_q;
  assign gate_o  = gate_q;
endmodule

// File: rtl/pnf_value_store.sv
module pnf_value_store
  import pnf_pkg::*;
#(
  parameter int NUM_IN    = 3,
  parameter int NUM_GATES = 6,
  parameter int NUM_OUT   = 2,
  localparam int GCNT_W   = $clog2(NUM_GATES + 1),
  localparam int GIDX_W   = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1,
  localparam int SRC_W    = $clog2(NUM_IN + NUM_GATES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_en_i,
  input  logic [GIDX_W-1:0]  load_idx_i,
  input  logic [1:0]         load_kind_i,
  input  logic [SRC_W-1:0]   load_src_a_i,
  input  logic [SRC_W-1:0]   load_src_b_i,
  input  logic               gate_fire_i,
  input  logic [GCNT_W-1:0]  gate_i,
  input  logic [NUM_IN-1:0]  combo_i,
  input  logic               mode2_i,
  output logic [NUM_OUT-1:0] out_vec_o
);
  gate_kind_e             kind_q  [NUM_GATES];
  logic [SRC_W-1:0]       src_a_q [NUM_GATES];
  logic [SRC_W-1:0]       src_b_q [NUM_GATES];
  logic [NUM_GATES-1:0]   val_q;

  // R4: inputs, then earlier gates; anything not yet computed reads 0
  function automatic logic read_src(input logic [SRC_W-1:0] idx,
                                    input logic [NUM_IN-1:0] inp,
                                    input logic [NUM_GATES-1:0] vals,
                                    input logic [GCNT_W-1:0] cur);
    int unsigned i;
    i = idx;
    if (i < NUM_IN) return inp[i];
    if ((i - NUM_IN) < cur) return vals[i - NUM_IN];
    return 1'b0;
  endfunction

  logic op_a, op_b, gate_res;

  always_comb begin
    op_a     = 1'b0;
    op_b     = 1'b0;
    gate_res = 1'b0;
    if (gate_fire_i) begin
      op_a     = read_src(src_a_q[gate_i], combo_i, val_q, gate_i);
      op_b     = read_src(src_b_q[gate_i], combo_i, val_q, gate_i);
      gate_res = gate_eval(kind_q[gate_i], mode2_i, op_a, op_b);
    end
  end

  // R10: netlist load port
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int g = 0; g < NUM_GATES; g++) begin
        kind_q[g]  <= GK_NAND_NOR;
        src_a_q[g] <= '0;
        src_b_q[g] <= '0;
      end
    end else if (load_en_i) begin
      kind_q[load_idx_i]  <= gate_kind_e'(load_kind_i);
      src_a_q[load_idx_i] <= load_src_a_i;
      src_b_q[load_idx_i] <= load_src_b_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) val_q <= '0;
    else if (gate_fire_i) val_q[gate_i] <= gate_res;
  end

  // R5: outputs are the topmost gates
  generate
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      assign out_vec_o[o] = val_q[NUM_GATES - NUM_OUT + o];
    end
  endgenerate
endmodule

// File: rtl/pnf_scorer.sv
module pnf_scorer #(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 2,
  localparam int TT_W   = (1 << NUM_IN) * NUM_OUT,
  localparam int FIT_W  = NUM_IN + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_acc_i,
  input  logic               cmp_fire_i,
  input  logic               mode2_i,
  input  logic               last_cmp_i,
  input  logic [NUM_IN-1:0]  combo_i,
  input  logic [NUM_OUT-1:0] out_vec_i,
  input  logic [TT_W-1:0]    tgt_m1_i,
  input  logic [TT_W-1:0]    tgt_m2_i,
  output logic [FIT_W-1:0]   fitness_o,
  output logic               done_o,
  output logic               point_o
);
  logic [NUM_OUT-1:0] expect_vec;
  logic               match, m1_ok_q;

  always_comb begin
    if (mode2_i) expect_vec = tgt_m2_i[int'(combo_i) * NUM_OUT +: NUM_OUT];
    else         expect_vec = tgt_m1_i[int'(combo_i) * NUM_OUT +: NUM_OUT];
  end

  assign match   = (out_vec_i == expect_vec);
  assign point_o = cmp_fire_i && mode2_i && m1_ok_q && match;   // R6

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      fitness_o <= '0;
      done_o    <= 1'b0;
      m1_ok_q   <= 1'b0;
    end else begin
      done_o <= last_cmp_i;
      if (start_acc_i) begin
        fitness_o <= '0;
        m1_ok_q   <= 1'b0;
      end else begin
        if (cmp_fire_i && !mode2_i) m1_ok_q <= match;
        if (point_o) fitness_o <= fitness_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/poly_fitness_eval.sv
module poly_fitness_eval #(
  parameter int NUM_IN    = 3,
  parameter int NUM_GATES = 6,
  parameter int NUM_OUT   = 2,
  localparam int GCNT_W   = $clog2(NUM_GATES + 1),
  localparam int GIDX_W   = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1,
  localparam int SRC_W    = $clog2(NUM_IN + NUM_GATES),
  localparam int TT_W     = (1 << NUM_IN) * NUM_OUT,
  localparam int FIT_W    = NUM_IN + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_en_i,
  input  logic [GIDX_W-1:0] load_idx_i,
  input  logic [1:0]        load_kind_i,
  input  logic [SRC_W-1:0]  load_src_a_i,
  input  logic [SRC_W-1:0]  load_src_b_i,
  input  logic [TT_W-1:0]   tgt_m1_i,
  input  logic [TT_W-1:0]   tgt_m2_i,
  output logic [FIT_W-1:0]  fitness_o,
  output logic              done_o
);
  logic               busy, mode2, gate_fire, cmp_fire, last_cmp, start_acc, point;
  logic [NUM_IN-1:0]  combo;
  logic [GCNT_W-1:0]  gate_idx;
  logic [NUM_OUT-1:0] out_vec;

  pnf_sequencer #(.NUM_IN(NUM_IN), .NUM_GATES(NUM_GATES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .busy_o(busy), .combo_o(combo), .mode2_o(mode2), .gate_o(gate_idx),
    .gate_fire_o(gate_fire), .cmp_fire_o(cmp_fire), .last_cmp_o(last_cmp),
    .start_acc_o(start_acc)
  );

  pnf_value_store #(.NUM_IN(NUM_IN), .NUM_GATES(NUM_GATES), .NUM_OUT(NUM_OUT)) u_vals (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_en_i(load_en_i), .load_idx_i(load_idx_i), .load_kind_i(load_kind_i),
    .load_src_a_i(load_src_a_i), .load_src_b_i(load_src_b_i),
    .gate_fire_i(gate_fire), .gate_i(gate_idx), .combo_i(combo), .mode2_i(mode2),
    .out_vec_o(out_vec)
  );

  pnf_scorer #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_score (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_acc_i(start_acc),
    .cmp_fire_i(cmp_fire), .mode2_i(mode2), .last_cmp_i(last_cmp),
    .combo_i(combo), .out_vec_i(out_vec),
    .tgt_m1_i(tgt_m1_i), .tgt_m2_i(tgt_m2_i),
    .fitness_o(fitness_o), .done_o(done_o), .point_o(point)
  );
endmodule

// File: rtl/poly_fitness_eval_chk.sv
module poly_fitness_eval_chk #(
  parameter int NUM_IN = 3,
  localparam int FIT_W = NUM_IN + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_req,
  input logic             start_acc,
  input logic             busy,
  input logic             done,
  input logic             point,
  input logic             cmp_fire,
  input logic             mode2,
  input logic [FIT_W-1:0] fitness
);
  localparam int NUM_COMB = 1 << NUM_IN;

  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (fitness == '0));

  assert_point_in_mode2_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    point |-> (cmp_fire && mode2));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fitness) <= NUM_COMB);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_acc) |=> $stable(fitness));

  assert_busy_start_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |-> !start_acc);
endmodule

bind poly_fitness_eval poly_fitness_eval_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .start_req(start_i), .start_acc(start_acc),
  .busy(busy), .done(done_o), .point(point), .cmp_fire(cmp_fire),
  .mode2(mode2), .fitness(fitness_o)
);

// File: tb/tb_poly_fitness_eval.sv
`timescale 1ns/1ps
module tb_poly_fitness_eval;
  localparam int NI = 3, NG = 6, NO = 2;
  localparam int NC = 1 << NI;
  localparam int SW = $clog2(NI + NG);
  localparam int IW = $clog2(NG);
  localparam int TW = NC * NO;
  localparam int RUN_T = NC * 2 * (NG + 1);

  logic clk = 0, rst_n = 0, start = 0, load_en = 0;
  logic [IW-1:0] load_idx = '0;
  logic [1:0]    load_kind = '0;
  logic [SW-1:0] load_a = '0, load_b = '0;
  logic [TW-1:0] tgt1 = '0, tgt2 = '0;
  logic [NI:0]   fitness;
  logic          done;

  int n_chk = 0, n_bad = 0;
  int bt [NG];
  int ba [NG];
  int bb [NG];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  poly_fitness_eval #(.NUM_IN(NI), .NUM_GATES(NG), .NUM_OUT(NO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .load_en_i(load_en),
    .load_idx_i(load_idx), .load_kind_i(load_kind), .load_src_a_i(load_a),
    .load_src_b_i(load_b), .tgt_m1_i(tgt1), .tgt_m2_i(tgt2),
    .fitness_o(fitness), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'(lfsr[15:0]);
  endfunction

  // bench model of one dual-behaviour gate
  function automatic int model_gate(int k, int m, int a, int b);
    if (k == 0) return (m == 0) ? ((a == 1 && b == 1) ? 0 : 1) : ((a == 0 && b == 0) ? 1 : 0);
    if (k == 1) return (m == 0) ? ((a + b) > 0 ? 1 : 0) : ((a + b) == 1 ? 1 : 0);
    if (k == 2) return (m == 0) ? ((a + b) == 1 ? 1 : 0) : ((a == 0 && b == 1) ? 1 : 0);
    return 0;
  endfunction

  function automatic int model_outs(int c, int m);
    int v [NG];
    int r, x, y;
    for (int g = 0; g < NG; g++) begin
      x = (ba[g] < NI) ? ((c >> ba[g]) & 1) : ((ba[g] - NI < g) ? v[ba[g] - NI] : 0);
      y = (bb[g] < NI) ? ((c >> bb[g]) & 1) : ((bb[g] - NI < g) ? v[bb[g] - NI] : 0);
      v[g] = model_gate(bt[g], m, x, y);
    end
    r = 0;
    for (int o = 0; o < NO; o++) r += v[NG - NO + o] << o;
    return r;
  endfunction

  function automatic int model_score();
    int s, e1, e2;
    s = 0;
    for (int c = 0; c < NC; c++) begin
      e1 = 0; e2 = 0;
      for (int o = 0; o < NO; o++) begin
        e1 += int'(tgt1[c * NO + o]) << o;
        e2 += int'(tgt2[c * NO + o]) << o;
      end
      if (model_outs(c, 0) == e1 && model_outs(c, 1) == e2) s++;
    end
    return s;
  endfunction

  task automatic load_all();
    for (int g = 0; g < NG; g++) begin
      @(negedge clk);
      load_en = 1; load_idx = IW'(g); load_kind = 2'(bt[g]);
      load_a = SW'(ba[g]); load_b = SW'(bb[g]);
      @(posedge clk);
    end
    @(negedge clk);
    load_en = 0;
  endtask

  // targets from the bench model, with optional flips
  task automatic set_targets(input logic [TW-1:0] flip1, input logic [TW-1:0] flip2);
    for (int c = 0; c < NC; c++) begin
      for (int o = 0; o < NO; o++) begin
        tgt1[c * NO + o] = 1'((model_outs(c, 0) >> o) & 1) ^ flip1[c * NO + o];
        tgt2[c * NO + o] = 1'((model_outs(c, 1) >> o) & 1) ^ flip2[c * NO + o];
      end
    end
  endtask

  task automatic run_eval(input int expect_fit, input bit poke, input string tag);
    @(negedge clk);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    check("R2 cleared after start", int'(fitness), 0);
    if (poke) begin
      repeat (20) @(posedge clk);
      @(negedge clk);
      start = 1;                       // R9: request during a run
      @(posedge clk);
      @(negedge clk);
      start = 0;
      repeat (RUN_T - 22) @(posedge clk);
    end else begin
      repeat (RUN_T - 1) @(posedge clk);
    end
    @(negedge clk);
    check("R7 done low before final edge", int'(done), 0);
    @(posedge clk);
    @(negedge clk);
    check("R7 done pulse", int'(done), 1);
    check({tag, " fitness"}, int'(fitness), expect_fit);
    @(posedge clk);
    @(negedge clk);
    check("R7 done single cycle", int'(done), 0);
  endtask

  initial begin
    #(150000 * 4);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int exp_fit;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 fitness in reset", int'(fitness), 0);
    check("R1 done in reset", int'(done), 0);
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    check("R1 fitness after reset", int'(fitness), 0);

    // known-good netlist exercising R3 kinds, R4 sources, R5 outputs
    bt[0] = 0; ba[0] = 0; bb[0] = 1;
    bt[1] = 1; ba[1] = 1; bb[1] = 2;
    bt[2] = 2; ba[2] = 3; bb[2] = 2;
    bt[3] = 1; ba[3] = 4; bb[3] = 5;
    bt[4] = 0; ba[4] = 6; bb[4] = 0;
    bt[5] = 2; ba[5] = 7; bb[5] = 4;
    load_all();
    set_targets('0, '0);
    run_eval(NC, 0, "R6 R3 R10 known-good max score");

    // R8: count held while idle
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R8 held after idle", int'(fitness), NC);

    // corrupted netlist: gate 4 forced to the zero kind (R3 code 3)
    bt[4] = 3;
    load_all();
    exp_fit = model_score();
    check("R6 corrupted scores below max", int'(exp_fit < NC), 1);
    run_eval(exp_fit, 0, "R6 R3 corrupted");

    // R4: forward reference reads 0
    bt[4] = 0; bb[2] = 8;
    load_all();
    set_targets('0, '0);
    run_eval(NC, 0, "R4 forward source");

    // R6: mode 1 only wrong on combo 2, mode 2 only wrong on combo 5
    set_targets(TW'(1) << (2 * NO), TW'(1) << (5 * NO + 1));
    run_eval(NC - 2, 0, "R6 single-mode mismatches");

    // R9: start during a run, same timing and count
    run_eval(NC - 2, 1, "R9 start ignored");

    // R5: all targets flipped gives zero
    set_targets('1, '0);
    run_eval(0, 0, "R5 inverted mode1 targets");

    // sweep of pseudo-random netlists
    for (int t = 0; t < 18; t++) begin
      for (int g = 0; g < NG; g++) begin
        bt[g] = rnd() % 4;
        ba[g] = (rnd() % 5 == 0) ? rnd() % (NI + NG) : rnd() % (NI + g);
        bb[g] = rnd() % (NI + g);
      end
      load_all();
      set_targets(TW'(rnd() & rnd() & rnd()), (t % 3 == 0) ? '0 : TW'(rnd() & rnd()));
      exp_fit = model_score();
      run_eval(exp_fit, (t % 4 == 1), "R6 R3 R4 sweep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule